// File: doc/BRIEF.md
# Scaled-Index Address Generator

This block forms the effective address for a load/store pipeline that offers several addressing forms. A request carries a 3-bit mode, a 64-bit base value, a 64-bit index value, a 2-bit scale exponent and a 32-bit signed displacement. The unit sums the base, an index term shifted left by the scale exponent, and a sign-extended displacement. The mode decides which of these terms take part. The sum wraps modulo 2^64, and no carry-out or overflow indication is produced.

Requests enter on a valid/ready stream. Results leave on a second valid/ready stream with one register stage between them, and each result carries an echo of the request's mode. The stage takes a new request whenever its output register is empty or is being drained in the same cycle. When the downstream side holds `out_ready` low while `out_valid` is high, the result stays frozen and `in_ready` falls. Upstream is expected to hold a request steady until it is accepted. Register file reads, memory access and permission checks happen elsewhere.

Top module: `sidx_agu`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `out_valid`, and it takes priority over a request accepted at the same edge.
- R2: Mode 3'd0 yields base plus the displacement sign-extended to 64 bits. Index and scale have no effect.
- R3: Mode 3'd1 yields base plus index. Scale and displacement have no effect.
- R4: Mode 3'd2 yields base plus index shifted left by the scale exponent (multipliers 1, 2, 4, 8 for exponents 0 to 3). Displacement has no effect.
- R5: Mode 3'd3 yields base plus the scaled index plus the sign-extended displacement.
- R6: Modes 3'd4 to 3'd7 yield the base alone.
- R7: All sums wrap modulo 2^64. Bits shifted out of the index are dropped.
- R8: A request accepted at an edge (`in_valid && in_ready`) appears at the next edge with `out_valid` high and `out_mode` equal to its mode. Results leave in acceptance order.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr` and `out_mode` keep their values at the next edge.
- R10: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. This allows one request per cycle under continuous draining.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_mode | input | 3 | Addressing mode code |
| in_base | input | 64 | Base register value |
| in_index | input | 64 | Index register value |
| in_scale | input | 2 | Index shift exponent |
| in_disp | input | 32 | Signed displacement |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_addr | output | 64 | Effective address |
| out_mode | output | 3 | Mode of the request that produced the result |

## Verification
Loading a new request and draining the held result can fall in the same cycle. This happens whenever `out_valid`, `out_ready` and `in_valid` are all high. A correct stage must replace the result without a bubble and without losing or repeating one. A first sweep drives a new request every cycle with the output always drained, so every cycle after the first is such a collision. Each result is compared in order against an arithmetic model, and its latency is checked to be exactly one cycle. A second sweep mixes upstream gaps with downstream stalls. It checks the ready relation every cycle, checks that stalled results stay frozen, and checks that ordering survives the mix.

// File: rtl/agu_pkg.sv
`timescale 1ns/1ps
package agu_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    AM_BASE_DISP   = 3'd0,
    AM_BASE_INDEX  = 3'd1,
    AM_SCALED      = 3'd2,
    AM_SCALED_DISP = 3'd3
  } agu_mode_e;

  typedef struct packed {
    logic use_index;
    logic use_shift;
    logic use_disp;
  } term_sel_t;
endpackage

// File: rtl/agu_mode_dec.sv
`timescale 1ns/1ps
module agu_mode_dec
  import agu_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output term_sel_t         sel
);
  always_comb begin
    sel = '0;
    case (mode)
      AM_BASE_DISP:   sel.use_disp  = 1'b1;
      AM_BASE_INDEX:  sel.use_index = 1'b1;
      AM_SCALED: begin
        sel.use_index = 1'b1;
        sel.use_shift = 1'b1;
      end
      AM_SCALED_DISP: begin
        sel.use_index = 1'b1;
        sel.use_shift = 1'b1;
        sel.use_disp  = 1'b1;
      end
      default: sel = '0;
    endcase
  end
endmodule

// File: rtl/agu_operand_prep.sv
`timescale 1ns/1ps
module agu_operand_prep
  import agu_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int DISP_W  = 32,
  parameter int SCALE_W = 2
) (
  input  term_sel_t          sel,
  input  logic [ADDR_W-1:0]  index,
  input  logic [SCALE_W-1:0] scale,
  input  logic [DISP_W-1:0]  disp,
  output logic [ADDR_W-1:0]  index_term,
  output logic [ADDR_W-1:0]  disp_term
);
  localparam int NSHIFT = 1 << SCALE_W;
  localparam int EXT_W  = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] shifted [NSHIFT];

  generate
    for (genvar g = 0; g < NSHIFT; g++) begin : g_shift
      assign shifted[g] = index << g;
    end
  endgenerate

  logic [ADDR_W-1:0] disp_ext;
  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};

  always_comb begin
    if (!sel.use_index)     index_term = '0;
    else if (sel.use_shift) index_term = shifted[scale];
    else                    index_term = index;
    disp_term = sel.use_disp ? disp_ext : '0;
  end
endmodule

// File: rtl/agu_sum3.sv
`timescale 1ns/1ps
module agu_sum3 #(
  parameter int W       = 64,
  parameter bit USE_CSA = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] sum
);
  generate
    if (USE_CSA) begin : g_csa
      logic [W-1:0] part_s;
      logic [W-1:0] part_c;
      assign part_s = a ^ b ^ c;
      assign part_c = ((a & b) | (a & c) | (b & c)) << 1;
      assign sum    = part_s + part_c;
    end else begin : g_chain
      assign sum = a + b + c;
    end
  endgenerate
endmodule

// File: rtl/agu_pipe_stage.sv
`timescale 1ns/1ps
module agu_pipe_stage #(
  parameter int W = 67
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign up_ready = !full_q || dn_ready;

  always_ff @(posedge clk) begin
    if (rst)           full_q <= 1'b0;
    else if (up_ready) full_q <= up_valid;
  end

  always_ff @(posedge clk) begin
    if (up_valid && up_ready) data_q <= up_data;
  end

  assign dn_valid = full_q;
  assign dn_data  = data_q;
endmodule

// File: rtl/sidx_agu.sv
`timescale 1ns/1ps
module sidx_agu
  import agu_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int DISP_W  = 32,
  parameter int SCALE_W = 2,
  parameter bit USE_CSA = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [MODE_W-1:0]  in_mode,
  input  logic [ADDR_W-1:0]  in_base,
  input  logic [ADDR_W-1:0]  in_index,
  input  logic [SCALE_W-1:0] in_scale,
  input  logic [DISP_W-1:0]  in_disp,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [MODE_W-1:0]  out_mode
);
  localparam int PAY_W = ADDR_W + MODE_W;

  term_sel_t         sel;
  logic [ADDR_W-1:0] index_term;
  logic [ADDR_W-1:0] disp_term;
  logic [ADDR_W-1:0] ea;
  logic [PAY_W-1:0]  pay_in;
  logic [PAY_W-1:0]  pay_out;

  agu_mode_dec u_dec (
    .mode (in_mode),
    .sel  (sel)
  );

  agu_operand_prep #(
    .ADDR_W  (ADDR_W),
    .DISP_W  (DISP_W),
    .SCALE_W (SCALE_W)
  ) u_prep (
    .sel        (sel),
    .index      (in_index),
    .scale      (in_scale),
    .disp       (in_disp),
    .index_term (index_term),
    .disp_term  (disp_term)
  );

  agu_sum3 #(
    .W       (ADDR_W),
    .USE_CSA (USE_CSA)
  ) u_sum (
    .a   (in_base),
    .b   (index_term),
    .c   (disp_term),
    .sum (ea)
  );

  assign pay_in = {in_mode, ea};

  agu_pipe_stage #(
    .W (PAY_W)
  ) u_stage (
    .clk      (clk),
    .rst      (rst),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (pay_in),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (pay_out)
  );

  assign out_addr = pay_out[ADDR_W-1:0];
  assign out_mode = pay_out[PAY_W-1:ADDR_W];
endmodule

// File: rtl/agu_chk.sv
`timescale 1ns/1ps
module agu_chk #(
  parameter int ADDR_W  = 64,
  parameter int DISP_W  = 32,
  parameter int SCALE_W = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic [2:0]         in_mode,
  input logic [ADDR_W-1:0]  in_base,
  input logic [ADDR_W-1:0]  in_index,
  input logic [SCALE_W-1:0] in_scale,
  input logic [DISP_W-1:0]  in_disp,
  input logic               out_valid,
  input logic               out_ready,
  input logic [ADDR_W-1:0]  out_addr,
  input logic [2:0]         out_mode
);
  logic take;
  logic [ADDR_W-1:0] sx_disp;
  logic [ADDR_W-1:0] scaled_idx;
  assign take       = in_valid && in_ready;
  assign sx_disp    = ADDR_W'($signed(in_disp));
  assign scaled_idx = in_index * (ADDR_W'(1) << in_scale);

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R2
  mode_disp_chk: assert property (@(posedge clk) disable iff (rst)
    (take && in_mode == 3'd0) |=> out_addr == $past(in_base) + $past(sx_disp));

  // R3
  mode_index_chk: assert property (@(posedge clk) disable iff (rst)
    (take && in_mode == 3'd1) |=> out_addr == $past(in_base) + $past(in_index));

  // R5
  mode_full_chk: assert property (@(posedge clk) disable iff (rst)
    (take && in_mode == 3'd3) |=> out_addr == $past(in_base) + $past(scaled_idx) + $past(sx_disp));

  // R6
  mode_other_chk: assert property (@(posedge clk) disable iff (rst)
    (take && in_mode[2]) |=> out_addr == $past(in_base));

  // R8
  latency_tag_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid && out_mode == $past(in_mode));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_addr) && $stable(out_mode));

  // R10
  stall_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R10
  empty_open_chk: assert property (@(posedge clk) disable iff (rst)
    (!out_valid || out_ready) |-> in_ready);
endmodule

bind sidx_agu agu_chk #(
  .ADDR_W  (ADDR_W),
  .DISP_W  (DISP_W),
  .SCALE_W (SCALE_W)
) u_chk (.*);

// File: tb/sim_sidx_agu.sv
`timescale 1ns/1ps
module sim_sidx_agu;
  localparam int NREQ = 256;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [2:0]  in_mode;
  logic [63:0] in_base;
  logic [63:0] in_index;
  logic [1:0]  in_scale;
  logic [31:0] in_disp;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] out_addr;
  logic [2:0]  out_mode;

  int n_checks = 0;
  int n_fails  = 0;

  logic [63:0] exp_q [$];
  logic [2:0]  mode_q [$];
  int          cyc_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  sidx_agu u0 (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_mode(in_mode),
    .in_base(in_base), .in_index(in_index), .in_scale(in_scale), .in_disp(in_disp),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_mode(out_mode)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] model(input logic [2:0] m, input logic [63:0] b,
                                        input logic [63:0] x, input logic [1:0] s,
                                        input logic [31:0] d);
    longint dl;
    logic [63:0] mul;
    dl  = longint'($signed(d));
    mul = 64'd1;
    for (int i = 0; i < int'(s); i++) mul = mul * 64'd2;
    case (m)
      3'd0:    return b + 64'(dl);
      3'd1:    return b + x;
      3'd2:    return b + x * mul;
      3'd3:    return b + x * mul + 64'(dl);
      default: return b;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] m, input int pat);
    if (pat == 2 || pat == 3) return "R7";
    case (m)
      3'd0:    return "R2";
      3'd1:    return "R3";
      3'd2:    return "R4";
      3'd3:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic apply(input int j, input int ph);
    int pat;
    pat      = (j >> 5) & 7;
    in_mode  = 3'(j);
    in_scale = 2'(j >> 3);
    case (pat)
      0: begin in_base = 64'h0;                   in_index = 64'h0;                   in_disp = 32'h0;        end
      1: begin in_base = 64'h1000;                in_index = 64'h10;                  in_disp = 32'hFFFF_FFFC; end
      2: begin in_base = 64'hFFFF_FFFF_FFFF_FFFF; in_index = 64'h1;                   in_disp = 32'h1;        end
      3: begin in_base = 64'h8000_0000_0000_0000; in_index = 64'hF000_0000_0000_0001; in_disp = 32'h7FFF_FFFF; end
      4: begin in_base = 64'h0123_4567_89AB_CDEF; in_index = 64'h100;                 in_disp = 32'h8000_0000; end
      5: begin in_base = 64'h40;                  in_index = 64'hFFFF_FFFF_FFFF_FFFF; in_disp = 32'h10;       end
      6: begin in_base = 64'hDEAD_BEEF_0000_0000; in_index = 64'h1234;                in_disp = 32'hFFFF_F000; end
      default: begin in_base = 64'h7FFF_FFFF_FFFF_FFF0; in_index = 64'h2;         in_disp = 32'h20;       end
    endcase
    if (ph != 0) begin
      in_base  = in_base ^ 64'hA5A5_0F0F_3C3C_9696;
      in_index = in_index + 64'(j * 3);
      in_disp  = in_disp ^ 32'(j << 20);
    end
  endtask

  task automatic run_phase(input int ph);
    int sent = 0;
    int got  = 0;
    int cyc  = 0;
    bit hold = 0;
    bit prev_stall = 0;
    logic [63:0] p_addr = '0;
    logic [2:0]  p_mode = '0;
    while (got < NREQ) begin
      @(negedge clk);
      out_ready = (ph == 0) ? 1'b1 : (((cyc % 3) != 1) && ((cyc % 7) != 3));
      if (sent < NREQ) begin
        in_valid = (ph == 0) || hold || ((cyc % 5) != 2);
        apply(sent, ph);
      end else begin
        in_valid = 1'b0;
      end
      #1;
      // R10: ready relation
      chk(in_ready == (!out_valid || out_ready), "R10", 64'(in_ready), 64'(!out_valid || out_ready));
      if (prev_stall) begin
        // R9: stalled result frozen
        chk(out_valid && out_addr == p_addr && out_mode == p_mode, "R9", out_addr, p_addr);
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", out_addr, 64'h0);
        end else begin
          chk(out_addr == exp_q[0], tag_q[0], out_addr, exp_q[0]);
          // R8: mode echo and ordering
          chk(out_mode == mode_q[0], "R8", 64'(out_mode), 64'(mode_q[0]));
          if (ph == 0) chk(cyc - cyc_q[0] == 1, "R8", 64'(cyc - cyc_q[0]), 64'd1);
          void'(exp_q.pop_front());
          void'(mode_q.pop_front());
          void'(cyc_q.pop_front());
          void'(tag_q.pop_front());
          got++;
        end
      end
      prev_stall = out_valid && !out_ready;
      p_addr = out_addr;
      p_mode = out_mode;
      hold = in_valid && !in_ready;
      if (in_valid && in_ready) begin
        exp_q.push_back(model(in_mode, in_base, in_index, in_scale, in_disp));
        mode_q.push_back(in_mode);
        cyc_q.push_back(cyc);
        tag_q.push_back(tag_of(in_mode, (sent >> 5) & 7));
        sent++;
      end
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    in_mode = '0; in_base = '0; in_index = '0; in_scale = '0; in_disp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R1: reset state
    chk(!out_valid, "R1", 64'(out_valid), 64'd0);
    rst = 1'b0;
    run_phase(0);
    run_phase(1);
    // R1: reset wins over a pending result
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; apply(37, 0);
    @(negedge clk); #1;
    chk(out_valid, "R8", 64'(out_valid), 64'd1);
    rst = 1'b1;
    @(negedge clk); #1;
    chk(!out_valid, "R1", 64'(out_valid), 64'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk); #1;
    chk(!out_valid, "R1", 64'(out_valid), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule